// File: doc/BRIEF.md
# Shaped Comfort Noise Generator

This block fills the silent gaps of a voice receiver with artificial background noise. A maximal-length linear feedback shift register of degree 31 is the noise source. Its update is unrolled, so each step yields a 32-bit word. Each word is cut into four signed bytes, and one byte is used per clock. The bytes pass through an 8-tap FIR filter with programmable 16-bit signed coefficients. A programmable gain and an arithmetic right shift then set the noise level, and the result is saturated to a 16-bit signed sample. While the enable input is held, the block delivers one shaped sample on every clock.

A small write-only port loads the filter coefficients, the gain, the shift amount and the register seed. Loading a seed restarts the byte sequence and empties the filter history, so a given seed, coefficient set and level give a repeatable noise stream.

Top module: `cng_noise_gen`

## Requirements
- R1: The register follows the bit-serial rule for x^31 + x^28 + 1. Each serial step computes fb = s[30] XOR s[27] and then sets s = {s[29:0], fb}. One 32-bit word collects 32 consecutive fb values, the first in bit 0, and leaves the state 32 steps further on.
- R2: The state is 1 after reset. A write of cfg_wdata to cfg_addr 10 loads state = cfg_wdata[30:0], with an all-zero value replaced by 1. The same write empties the filter history and restarts the byte order at byte 0. The state is never zero.
- R3: On each enabled clock, one byte is drawn as a signed two's-complement sample, least significant byte first (bits 7:0, 15:8, 23:16, 31:24). A new word is generated on every fourth enabled clock. When enable is low, the byte order restarts at byte 0 and the unused bytes of the current word are discarded.
- R4: The filter computes y = sum over k = 0..7 of c[k] * x[n-k]. Here x[n] is the newest sample, and c[k] is the signed 16-bit value written to cfg_addr k (cfg_wdata[15:0]). All coefficients are 0 after reset.
- R5: The output is (y * g) >>> s, saturated to the range -32768..32767. Here g is the unsigned 16-bit gain at cfg_addr 8 (cfg_wdata[15:0]) and s is the shift at cfg_addr 9 (cfg_wdata[4:0]). Both are 0 after reset.
- R6: A sample drawn at one rising edge appears on noise_out after the next rising edge. noise_valid at each edge equals the value enable had two edges earlier. After reset, noise_out is 0 and noise_valid is 0.
- R7: With enable low, the filter history does not change. When no sample is in flight, noise_out holds its value, even if the configuration is rewritten.
- R8: Instantiated with a degree-7 polynomial (x^7 + x^6 + 1), the byte stream repeats every 4 * (2^7 - 1) = 508 samples and does not repeat at a 4-sample lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Produce one noise sample per clock while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0..7 coefficient, 8 gain, 9 shift, 10 seed |
| cfg_wdata | input | 32 | Configuration write data |
| noise_out | output | 16 | Shaped, scaled, saturated noise sample |
| noise_valid | output | 1 | noise_out carries a fresh sample |

## Verification
First, a single unit coefficient with unity gain passes the raw bytes straight through. This separates errors in the register update and the byte order from errors in the filter. Next, mixed-sign coefficients test the tap alignment and sign handling, which a pure pass-through cannot reveal. Large coefficients and full gain, and then a deep shift, drive the output into both saturation limits and into the truncating shift. Broken enable bursts, a zero seed, and a degree-7 instance whose output is checked for a 508-sample repeat cover the restart, seed-replacement and period rules.

// File: rtl/cng_pkg.sv
package cng_pkg;
    localparam int CFG_AW     = 4;
    localparam int CFG_DW     = 32;
    // coefficient slots occupy addresses 0 .. taps-1 (taps <= 8)
    localparam logic [CFG_AW-1:0] ADDR_GAIN  = 4'd8;
    localparam logic [CFG_AW-1:0] ADDR_SHIFT = 4'd9;
    localparam logic [CFG_AW-1:0] ADDR_SEED  = 4'd10;
endpackage

// File: rtl/cng_lfsr_word.sv
module cng_lfsr_word #(
    parameter int DEG    = 31,
    parameter int TAP    = 28,
    parameter int WORD_W = 32
) (
    input  logic [DEG-1:0]    state,
    output logic [DEG-1:0]    state_next,
    output logic [WORD_W-1:0] word
);
    logic [DEG-1:0] s;
    logic           fb;

    // WORD_W serial steps flattened into one XOR network
    always_comb begin
        s    = state;
        fb   = 1'b0;
        word = '0;
        for (int i = 0; i < WORD_W; i++) begin
            fb      = s[DEG-1] ^ s[TAP-1];
            s       = {s[DEG-2:0], fb};
            word[i] = fb;
        end
        state_next = s;
    end
endmodule

// File: rtl/cng_fir.sv
module cng_fir #(
    parameter int TAPS   = 8,
    parameter int SAMP_W = 8,
    parameter int COEF_W = 16,
    parameter int ACC_W  = SAMP_W + COEF_W + $clog2(TAPS)
) (
    input  logic [TAPS-1:0][SAMP_W-1:0] samp,
    input  logic [TAPS-1:0][COEF_W-1:0] coef,
    output logic signed [ACC_W-1:0]     acc
);
    localparam int PW = SAMP_W + COEF_W;

    logic signed [PW-1:0] prod [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign prod[k] = $signed(samp[k]) * $signed(coef[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + {{(ACC_W-PW){prod[k][PW-1]}}, prod[k]};
        end
    end
endmodule

// File: rtl/cng_scale.sv
module cng_scale #(
    parameter int ACC_W  = 27,
    parameter int GAIN_W = 16,
    parameter int SH_W   = 5,
    parameter int OUT_W  = 16
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic [GAIN_W-1:0]       gain,
    input  logic [SH_W-1:0]         shift,
    output logic [OUT_W-1:0]        res
);
    localparam int PW = ACC_W + GAIN_W + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] shifted;

    always_comb begin
        full    = acc * $signed({1'b0, gain});
        shifted = full >>> shift;
        if (shifted > MAXV) begin
            res = MAXV[OUT_W-1:0];
        end else if (shifted < MINV) begin
            res = MINV[OUT_W-1:0];
        end else begin
            res = shifted[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/cng_noise_gen.sv
module cng_noise_gen #(
    parameter int DEG    = 31,
    parameter int TAP    = 28,
    parameter int WORD_W = 32,
    parameter int SAMP_W = 8,
    parameter int TAPS   = 8,
    parameter int COEF_W = 16,
    parameter int GAIN_W = 16,
    parameter int SH_W   = 5,
    parameter int OUT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       cfg_we,
    input  logic [cng_pkg::CFG_AW-1:0] cfg_addr,
    input  logic [cng_pkg::CFG_DW-1:0] cfg_wdata,
    output logic [OUT_W-1:0]           noise_out,
    output logic                       noise_valid
);
    import cng_pkg::*;

    localparam int BYTES = WORD_W / SAMP_W;
    localparam int PH_W  = $clog2(BYTES);
    localparam int ACC_W = SAMP_W + COEF_W + $clog2(TAPS);

    typedef struct packed {
        logic [DEG-1:0]                  lfsr;
        logic [WORD_W-1:0]               word;
        logic [PH_W-1:0]                 ph;
        logic [TAPS-1:0][SAMP_W-1:0]     dly;
        logic [TAPS-1:0][COEF_W-1:0]     coef;
        logic [GAIN_W-1:0]               gain;
        logic [SH_W-1:0]                 shift;
        logic                            v1;
        logic                            valid;
        logic [OUT_W-1:0]                out;
    } st_t;

    st_t st_q, st_d;

    logic [DEG-1:0]          lf_next;
    logic [WORD_W-1:0]       lf_word;
    logic signed [ACC_W-1:0] fir_acc;
    logic [OUT_W-1:0]        scaled;
    logic                    ld_seed;
    logic                    draw;
    logic [SAMP_W-1:0]       smp;
    logic [DEG-1:0]          seed_v;

    cng_lfsr_word #(.DEG(DEG), .TAP(TAP), .WORD_W(WORD_W)) u_lfsr (
        .state      (st_q.lfsr),
        .state_next (lf_next),
        .word       (lf_word)
    );

    cng_fir #(.TAPS(TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_fir (
        .samp (st_q.dly),
        .coef (st_q.coef),
        .acc  (fir_acc)
    );

    cng_scale #(.ACC_W(ACC_W), .GAIN_W(GAIN_W), .SH_W(SH_W), .OUT_W(OUT_W)) u_scale (
        .acc   (fir_acc),
        .gain  (st_q.gain),
        .shift (st_q.shift),
        .res   (scaled)
    );

    always_comb begin
        st_d    = st_q;
        ld_seed = cfg_we && (cfg_addr == ADDR_SEED);
        draw    = en && !ld_seed;
        seed_v  = cfg_wdata[DEG-1:0];
        smp     = lf_word[SAMP_W-1:0];

        // output stage: scale the history registered last cycle
        if (st_q.v1) begin
            st_d.out = scaled;
        end
        st_d.valid = st_q.v1;
        st_d.v1    = draw;

        // sample stage
        if (ld_seed) begin
            st_d.lfsr = (seed_v == '0) ? DEG'(1) : seed_v;
            st_d.ph   = '0;
            st_d.dly  = '0;
        end else if (draw) begin
            if (st_q.ph == '0) begin
                st_d.word = lf_word;
                st_d.lfsr = lf_next;
            end else begin
                for (int b = 1; b < BYTES; b++) begin
                    if (st_q.ph == PH_W'(b)) begin
                        smp = st_q.word[b*SAMP_W +: SAMP_W];
                    end
                end
            end
            st_d.dly = {st_q.dly[TAPS-2:0], smp};
            st_d.ph  = st_q.ph + PH_W'(1);
        end else begin
            st_d.ph = '0;
        end

        // configuration writes
        if (cfg_we) begin
            for (int k = 0; k < TAPS; k++) begin
                if (cfg_addr == CFG_AW'(k)) begin
                    st_d.coef[k] = cfg_wdata[COEF_W-1:0];
                end
            end
            if (cfg_addr == ADDR_GAIN) begin
                st_d.gain = cfg_wdata[GAIN_W-1:0];
            end
            if (cfg_addr == ADDR_SHIFT) begin
                st_d.shift = cfg_wdata[SH_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= DEG'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign noise_out   = st_q.out;
    assign noise_valid = st_q.valid;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        noise_valid |-> $past(en, 2)); // R6
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld_seed) |=> (st_q.ph == $past(st_q.ph) + PH_W'(1))); // R3
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld_seed && st_q.ph != '0) |=> $stable(st_q.lfsr)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.v1 |=> $stable(noise_out)); // R7
    AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld_seed) |=> $stable(st_q.dly)); // R7
endmodule

// File: tb/cng_noise_gen_bench.sv
module cng_noise_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] noise_out, b_out;
    logic        noise_valid, b_valid;

    int checks = 0;
    int errors = 0;
    string tag = "R6 reset";
    bit cmp_on = 1'b0;
    bit collect = 1'b0;
    int b_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cng_noise_gen u_cng_noise_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .noise_out(noise_out), .noise_valid(noise_valid)
    );

    cng_noise_gen #(.DEG(7), .TAP(6)) u_cng_noise_gen_short (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .noise_out(b_out), .noise_valid(b_valid)
    );

    // behavioural reference
    bit [30:0] m_lfsr;
    bit [31:0] m_word;
    int        m_ph;
    int        m_hist[8];
    int        m_coef[8];
    longint    m_gain, m_shift;
    bit        m_v1, m_valid;
    longint    m_out;

    function automatic bit [31:0] gen_word();
        bit [31:0] w;
        bit b;
        for (int i = 0; i < 32; i++) begin
            b = m_lfsr[30] ^ m_lfsr[27];
            m_lfsr = {m_lfsr[29:0], b};
            w[i] = b;
        end
        return w;
    endfunction

    function automatic longint model_level();
        longint acc = 0;
        for (int k = 0; k < 8; k++) acc += longint'(m_coef[k]) * longint'(m_hist[k]);
        acc = (acc * m_gain) >>> m_shift;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    always @(posedge clk) begin
        bit ld;
        bit [30:0] sv;
        if (!rst_n) begin
            m_lfsr = 31'd1; m_word = '0; m_ph = 0;
            for (int k = 0; k < 8; k++) begin m_hist[k] = 0; m_coef[k] = 0; end
            m_gain = 0; m_shift = 0; m_v1 = 0; m_valid = 0; m_out = 0;
        end else begin
            ld = cfg_we && cfg_addr == 4'd10;
            if (m_v1) m_out = model_level();
            m_valid = m_v1;
            m_v1 = en && !ld;
            if (ld) begin
                sv = cfg_wdata[30:0];
                m_lfsr = (sv == 0) ? 31'd1 : sv;
                m_ph = 0;
                for (int k = 0; k < 8; k++) m_hist[k] = 0;
            end else if (en) begin
                if (m_ph == 0) m_word = gen_word();
                for (int k = 7; k > 0; k--) m_hist[k] = m_hist[k-1];
                m_hist[0] = int'($signed(m_word[8*m_ph +: 8]));
                m_ph = (m_ph + 1) % 4;
            end else begin
                m_ph = 0;
            end
            if (cfg_we && cfg_addr < 4'd8) m_coef[cfg_addr] = int'($signed(cfg_wdata[15:0]));
            if (cfg_we && cfg_addr == 4'd8) m_gain = longint'(cfg_wdata[15:0]);
            if (cfg_we && cfg_addr == 4'd9) m_shift = longint'(cfg_wdata[4:0]);
        end
    end

    task automatic chk(string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("valid (R6)", longint'(noise_valid), longint'(m_valid));
            chk("sample", longint'($signed(noise_out)), m_out);
        end
        if (rst_n && collect && b_valid) b_q.push_back(int'($signed(b_out)));
    end

    task automatic wr(int addr, logic [31:0] data);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(bit e, int n);
        en = e;
        repeat (n) @(negedge clk);
    endtask

    task automatic passthru();
        wr(0, 32'd1);
        for (int k = 1; k < 8; k++) wr(k, 32'd0);
        wr(8, 32'd1);
        wr(9, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit moved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R2/R6 reset state";
        chk("out", longint'(noise_out), 0);
        chk("valid", longint'(noise_valid), 0);
        cmp_on = 1'b1;

        tag = "R1 sequence";
        passthru();
        wr(10, 32'h0123_4567);
        run(1, 40);
        tag = "R7 hold while disabled";
        run(0, 6);
        wr(3, 32'd77);            // rewrite while idle: output must not move
        run(0, 3);
        wr(3, 32'd0);

        tag = "R3 byte order and bursts";
        run(1, 6); run(0, 3); run(1, 10); run(0, 1); run(1, 3); run(0, 4);

        tag = "R2 zero seed";
        wr(10, 32'h0);
        run(1, 24); run(0, 3);

        tag = "R4 filter taps";
        wr(0, 32'd3);    wr(1, 32'hFFFE); wr(2, 32'd5);    wr(3, 32'hFF00);
        wr(4, 32'd1000); wr(5, 32'h8000); wr(6, 32'd7);    wr(7, 32'h7FFF);
        wr(10, 32'h2AAA_5555);
        run(1, 50); run(0, 3);

        tag = "R5 saturation";
        for (int k = 0; k < 8; k++) wr(k, 32'h7FFF);
        wr(8, 32'hFFFF);
        run(1, 30); run(0, 3);
        tag = "R5 shift";
        wr(8, 32'd300); wr(9, 32'd20);
        run(1, 30); run(0, 3);

        tag = "R4 period run";
        passthru();
        wr(10, 32'h5A);
        collect = 1'b1;
        run(1, 1100);
        collect = 1'b0;
        run(0, 3);

        tag = "R8 short period";
        chk("collected", longint'(b_q.size() >= 1016), 1);
        if (b_q.size() >= 1016) begin
            moved = 1'b0;
            for (int n = 0; n < 508; n++) begin
                chk("repeat at 508", longint'(b_q[n + 508]), longint'(b_q[n]));
                if (b_q[n + 4] != b_q[n]) moved = 1'b1;
            end
            chk("no 4-sample repeat", longint'(moved), 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule